// File: doc/BRIEF.md
# Prescaled Timer with Four Match Channels

The block is a counting timer. A prescale counter runs on every enabled clock. Each time it reaches a programmable limit it returns to zero and the main count steps by one. Four match channels each compare a match value against the main count. Per-channel action bits choose what a match does: set a sticky interrupt flag, return the count to zero, or halt the timer and drop its enable.

Match values are double-buffered. Each channel has a shadow value. When that channel's reload bit is set, the shadow is copied into the live match value each time the count is zeroed. The zeroing can come from a reset-on-match or from a software write that sets the timer-control reset bit. Software can therefore change a period on a clean boundary.

Software programs the block through a one-cycle write port: an enable, a 4-bit word address and a 32-bit data word. Register map by word address:
- 0: timer control. Bit 0 is run, bit 1 is held reset.
- 1: match control word.
- 2: prescale limit.
- 3: interrupt flags, write one to clear.
- 4+n: live match value of channel n.
- 8+n: shadow value of channel n.

Top module: `match_timer`

## Requirements
- R1: After reset the count, the prescale counter, all interrupt flags and the run bit are zero, and the match control word is zero.
- R2: While the run bit (address 0, bit 0) is set and the held-reset bit is clear, the prescale counter increments each clock. On the clock where it is at or above the prescale limit (address 2), it returns to zero and the count increments by one. With the run bit clear, both counters hold.
- R3: When control bit 3n (interrupt on match) is set and channel n's match value equals the count on a prescale wrap, flag n (irq_o[n]) is set one clock later. The flag stays set until a write to address 3 with data bit n set clears it. A set in the same clock wins over the clear.
- R4: When control bit 3n+1 (zero on match) is set and channel n matches on a prescale wrap, the count becomes zero instead of incrementing.
- R5: When control bit 3n+2 (stop on match) is set and channel n matches on a prescale wrap, the run bit is cleared and the count holds its value, unless a zero-on-match applies in the same clock. The stop wins over a same-clock write to the run bit.
- R6: Matches are tested only on prescale wraps. A count that equals a match value while the timer is halted or between wraps raises no action.
- R7: When control bit 24+n is set, channel n's match value is loaded from its shadow (address 8+n) on the clock the count is zeroed by a match. The shadow value used is the one held before that clock.
- R8: A write to address 0 with data bit 1 set also reloads every channel whose reload bit is set. While bit 1 stays set, the count and the prescale counter are held at zero.
- R9: When several channels match on the same wrap, every action they request is applied in that clock.
- R10: Control bits 12 to 23 and 28 to 31 have no effect on the timer.
- R11: With a channel's reload bit clear, its match value is kept across every zeroing of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Main timer count |
| prescale_o | output | 32 | Prescale counter |
| irq_o | output | 4 | Sticky per-channel interrupt flags |
| running_o | output | 1 | Run bit of the timer control register |

## Verification
Some properties are checked on every clock by the embedded assertions:
- A prescale wrap returns the prescale counter to zero, and a non-wrap steps it by one.
- The count is frozen while halted and zero while held reset.
- A requested zero-on-match leaves the count at zero.
- A requested stop drops the run bit.
- A flag is set by its match and survives until a clearing write.
- A reload copies the previous shadow value.

Other behaviour only the bench scenarios can show:
- A reloaded period actually taking effect on the next pass.
- The unused control bits staying inert.
- Two channels acting together on one wrap.
- A halted timer sitting on its match value without raising the flag again.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

   // register word addresses
   localparam int unsigned REG_TCTRL       = 0;
   localparam int unsigned REG_MCTRL       = 1;
   localparam int unsigned REG_PRESC       = 2;
   localparam int unsigned REG_FLAGS       = 3;
   localparam int unsigned REG_MATCH_BASE  = 4;
   localparam int unsigned REG_SHADOW_BASE = 8;
   localparam int unsigned REG_SPAN        = 12;

   // control word layout
   localparam int unsigned MAX_CH      = 4;
   localparam int unsigned BITS_PER_CH = 3;
   localparam int unsigned RELOAD_BASE = 24;

   typedef enum int unsigned {
      ACT_IRQ  = 0,
      ACT_ZERO = 1,
      ACT_STOP = 2
   } act_e;

   typedef struct packed {
      logic irq;
      logic zero;
      logic stop;
      logic reload;
   } chan_ctl_t;

   function automatic int unsigned act_bit(int unsigned ch, act_e a);
      return ch * BITS_PER_CH + int'(a);
   endfunction

   function automatic int unsigned reload_bit(int unsigned ch);
      return RELOAD_BASE + ch;
   endfunction

endpackage

// File: rtl/match_timer_prescale.sv
module match_timer_prescale #(
   parameter int unsigned PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [PRE_W-1:0] limit_i,
   output logic [PRE_W-1:0] pc_o,
   output logic             tick_o
);

   logic [PRE_W-1:0] pc_q;

   assign tick_o = run_i && (pc_q >= limit_i);
   assign pc_o   = pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (clr_i) begin
         pc_q <= '0;
      end else if (run_i) begin
         if (tick_o) pc_q <= '0;
         else        pc_q <= pc_q + 1'b1;
      end
   end

   AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (pc_q == '0)); // R2

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_o && !clr_i) |=> (pc_q == $past(pc_q) + 1'b1)); // R2

endmodule

// File: rtl/match_timer_count.sv
module match_timer_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             zero_i,
   input  logic             hold_i,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (zero_i)       cnt_q <= '0;
         else if (!hold_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;

   AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0)); // R8

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/match_timer_chan.sv
module match_timer_chan
   import match_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              tick_i,
   input  logic              zero_evt_i,
   input  chan_ctl_t         ctl_i,
   output logic              hit_o,
   output logic              flag_o
);

   localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(REG_MATCH_BASE + IDX);
   localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(REG_SHADOW_BASE + IDX);
   localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(REG_FLAGS);

   logic [CNT_W-1:0] mr_q;
   logic [CNT_W-1:0] sh_q;
   logic             flag_q;
   logic             wr_match, wr_shadow, clr_flag, set_flag;

   assign wr_match  = wr_en && (wr_addr == A_MATCH);
   assign wr_shadow = wr_en && (wr_addr == A_SHADOW);
   assign clr_flag  = wr_en && (wr_addr == A_FLAGS) && wr_data[IDX];
   assign hit_o     = (mr_q == count_i);
   assign set_flag  = tick_i && hit_o && ctl_i.irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mr_q   <= '0;
         sh_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_shadow) sh_q <= wr_data[CNT_W-1:0];

         if (zero_evt_i && ctl_i.reload) mr_q <= sh_q;
         else if (wr_match)              mr_q <= wr_data[CNT_W-1:0];

         if (set_flag)      flag_q <= 1'b1;
         else if (clr_flag) flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && hit_o && ctl_i.irq) |=> flag_q); // R3

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_flag) |=> flag_q); // R3

   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt_i && ctl_i.reload) |=> (mr_q == $past(sh_q))); // R7

   AST_KEEP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt_i && !ctl_i.reload && !wr_match) |=> $stable(mr_q)); // R11

endmodule

// File: rtl/match_timer.sv
module match_timer
   import match_timer_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PRE_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [PRE_W-1:0]  prescale_o,
   output logic [NUM_CH-1:0] irq_o,
   output logic              running_o
);

   localparam int unsigned CTL_TOP = RELOAD_BASE + MAX_CH;
   localparam logic [ADDR_W-1:0] A_TCTRL = ADDR_W'(REG_TCTRL);
   localparam logic [ADDR_W-1:0] A_MCTRL = ADDR_W'(REG_MCTRL);
   localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(REG_PRESC);

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("match_timer: NUM_CH must be between 1 and 4");
   end
   if (DATA_W < CTL_TOP) begin : g_bad_data
      $error("match_timer: DATA_W too narrow for the control word");
   end
   if (CNT_W > DATA_W || PRE_W > DATA_W) begin : g_bad_cnt
      $error("match_timer: counter widths must fit the write data");
   end
   if ((1 << ADDR_W) < REG_SPAN) begin : g_bad_addr
      $error("match_timer: ADDR_W too narrow for the register map");
   end

   logic [1:0]        tcr_q;   // [0] run, [1] held reset
   logic [PRE_W-1:0]  pr_q;
   chan_ctl_t         ctl_q [NUM_CH];
   logic [NUM_CH-1:0] hit, zero_mask, stop_mask, flags;
   logic              run, tick, zero_req, stop_req, sw_zero, zero_evt;
   logic              wr_tctrl, wr_mctrl, wr_presc;

   assign wr_tctrl = wr_en && (wr_addr == A_TCTRL);
   assign wr_mctrl = wr_en && (wr_addr == A_MCTRL);
   assign wr_presc = wr_en && (wr_addr == A_PRESC);

   assign run      = tcr_q[0] && !tcr_q[1];
   assign zero_req = tick && |(hit & zero_mask);
   assign stop_req = tick && |(hit & stop_mask);
   assign sw_zero  = wr_tctrl && wr_data[1];
   assign zero_evt = zero_req || sw_zero;

   // timer control and prescale limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcr_q <= '0;
         pr_q  <= '0;
      end else begin
         if (wr_tctrl) tcr_q    <= wr_data[1:0];
         if (stop_req) tcr_q[0] <= 1'b0;
         if (wr_presc) pr_q     <= wr_data[PRE_W-1:0];
      end
   end

   // per-channel control fields and channels
   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_q[n] <= '0;
         end else if (wr_mctrl) begin
            ctl_q[n].irq    <= wr_data[act_bit(n, ACT_IRQ)];
            ctl_q[n].zero   <= wr_data[act_bit(n, ACT_ZERO)];
            ctl_q[n].stop   <= wr_data[act_bit(n, ACT_STOP)];
            ctl_q[n].reload <= wr_data[reload_bit(n)];
         end
      end

      assign zero_mask[n] = ctl_q[n].zero;
      assign stop_mask[n] = ctl_q[n].stop;

      match_timer_chan #(
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W),
         .IDX    (n)
      ) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_en),
         .wr_addr    (wr_addr),
         .wr_data    (wr_data),
         .count_i    (count_o),
         .tick_i     (tick),
         .zero_evt_i (zero_evt),
         .ctl_i      (ctl_q[n]),
         .hit_o      (hit[n]),
         .flag_o     (flags[n])
      );
   end

   match_timer_prescale #(.PRE_W(PRE_W)) presc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tcr_q[1]),
      .run_i   (run),
      .limit_i (pr_q),
      .pc_o    (prescale_o),
      .tick_o  (tick)
   );

   match_timer_count #(.CNT_W(CNT_W)) count_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tcr_q[1]),
      .tick_i  (tick),
      .zero_i  (zero_req),
      .hold_i  (stop_req),
      .count_o (count_o)
   );

   assign irq_o     = flags;
   assign running_o = tcr_q[0];

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !running_o); // R5

   AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      zero_req |=> (count_o == '0)); // R4

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !zero_req && !tcr_q[1]) |=> $stable(count_o)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tcr_q[0] && !tcr_q[1]) |=> ($stable(count_o) && $stable(prescale_o))); // R2

   AST_HELD_PC: assert property (@(posedge clk) disable iff (!rst_n)
      tcr_q[1] |=> (prescale_o == '0)); // R8

endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] count_o, prescale_o;
   logic [3:0]  irq_o;
   logic        running_o;

   int          n_total = 0;
   int          n_fail  = 0;
   string       cur_req = "R1";

   always #5 clk = ~clk;

   match_timer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .count_o    (count_o),
      .prescale_o (prescale_o),
      .irq_o      (irq_o),
      .running_o  (running_o)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_tc, m_pc, m_pr, m_ctl;
   logic [31:0] m_mr [4];
   logic [31:0] m_sh [4];
   logic [3:0]  m_flag;
   logic        m_run, m_hold;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tc = 0; m_pc = 0; m_pr = 0; m_ctl = 0; m_flag = 0;
         m_run = 0; m_hold = 0;
         for (int i = 0; i < 4; i++) begin m_mr[i] = 0; m_sh[i] = 0; end
      end else begin
         bit tk, zr, st, swz;
         bit [3:0] h;
         tk = m_run && !m_hold && (m_pc >= m_pr);
         zr = 0; st = 0;
         for (int i = 0; i < 4; i++) begin
            h[i] = (m_mr[i] == m_tc);
            if (tk && h[i] && m_ctl[3*i+1]) zr = 1;
            if (tk && h[i] && m_ctl[3*i+2]) st = 1;
         end
         swz = wr_en && wr_addr == 0 && wr_data[1];
         if (m_hold) m_tc = 0;
         else if (tk) begin
            if (zr) m_tc = 0;
            else if (!st) m_tc = m_tc + 1;
         end
         if (m_hold) m_pc = 0;
         else if (m_run) m_pc = tk ? 0 : m_pc + 1;
         for (int i = 0; i < 4; i++) begin
            if (tk && h[i] && m_ctl[3*i]) m_flag[i] = 1;
            else if (wr_en && wr_addr == 3 && wr_data[i]) m_flag[i] = 0;
            if (((tk && zr) || swz) && m_ctl[24+i]) m_mr[i] = m_sh[i];
            else if (wr_en && wr_addr == 4'(4+i)) m_mr[i] = wr_data;
            if (wr_en && wr_addr == 4'(8+i)) m_sh[i] = wr_data;
         end
         if (wr_en && wr_addr == 1) m_ctl = wr_data;
         if (wr_en && wr_addr == 2) m_pr = wr_data;
         if (wr_en && wr_addr == 0) begin m_run = wr_data[0]; m_hold = wr_data[1]; end
         if (st) m_run = 0;
      end
   end

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_total++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, "count", count_o, m_tc);
         check(cur_req, "prescale", prescale_o, m_pc);
         check(cur_req, "irq", {28'd0, irq_o}, {28'd0, m_flag});
         check(cur_req, "running", {31'd0, running_o}, {31'd0, m_run});
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input logic [31:0] ctl, input logic [31:0] pr);
      wr(0, 32'h2);
      wr(1, ctl);
      wr(2, pr);
      wr(3, 32'hF);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] mx;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1", "count", count_o, 0);
      check("R1", "prescale", prescale_o, 0);
      check("R1", "irq", {28'd0, irq_o}, 0);
      check("R1", "running", {31'd0, running_o}, 0);
      rst_n = 1'b1;
      idle(3);
      check("R1", "idle count", count_o, 0);

      // R2: prescale by 3, then halt
      cur_req = "R2";
      wr(2, 2);
      wr(0, 1);
      idle(20);
      wr(0, 0);
      mx = count_o;
      idle(6);
      check("R2", "halted count", count_o, mx);

      // R3 / R4: periodic zero at 5 with interrupt
      cur_req = "R4";
      restart(32'h3, 0);
      wr(4, 5);
      wr(0, 1);
      mx = 0;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (count_o > mx) mx = count_o;
      end
      check("R4", "max count", mx, 5);
      cur_req = "R3";
      check("R3", "flag0 set", {31'd0, irq_o[0]}, 1);
      wr(3, 32'h1);
      idle(10);

      // R5 / R6: stop on channel 2 at 3, prescale 5
      cur_req = "R5";
      restart(32'h140, 4);
      wr(6, 3);
      wr(0, 1);
      idle(30);
      check("R5", "stopped", {31'd0, running_o}, 0);
      check("R5", "count held", count_o, 3);
      cur_req = "R6";
      wr(3, 32'h4);
      idle(10);
      check("R6", "no match while halted", {31'd0, irq_o[2]}, 0);
      wr(0, 1);
      idle(8);
      check("R6", "match on next wrap", {31'd0, irq_o[2]}, 1);
      check("R6", "stopped again", {31'd0, running_o}, 0);

      // R7: reload from shadow on match zeroing
      cur_req = "R7";
      restart(32'h0100_0002, 0);
      wr(4, 4);
      wr(8, 7);
      wr(0, 1);
      mx = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (count_o > mx) mx = count_o;
      end
      check("R7", "reloaded period", mx, 7);

      // R11: no reload when the enable is clear
      cur_req = "R11";
      restart(32'h2, 0);
      wr(4, 3);
      wr(8, 9);
      wr(0, 1);
      mx = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (count_o > mx) mx = count_o;
      end
      check("R11", "period kept", mx, 3);

      // R8: software zeroing reloads and holds
      cur_req = "R8";
      restart(32'h0200_0008, 0);
      wr(5, 100);
      wr(9, 2);
      wr(0, 1);
      idle(4);
      wr(0, 3);
      idle(3);
      check("R8", "held count", count_o, 0);
      check("R8", "held prescale", prescale_o, 0);
      wr(0, 1);
      idle(8);
      check("R8", "reloaded match fires", {31'd0, irq_o[1]}, 1);

      // R9: two channels on the same wrap
      cur_req = "R9";
      restart(32'h0000_0601, 1);
      wr(4, 6);
      wr(7, 6);
      wr(0, 1);
      idle(20);
      check("R9", "both flags", {28'd0, irq_o}, 32'h9);
      mx = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (count_o > mx) mx = count_o;
      end
      check("R9", "zeroed at 6", mx, 6);

      // R10: unused control bits are inert
      cur_req = "R10";
      restart(32'hF0FF_F000, 0);
      wr(4, 2);
      wr(0, 1);
      idle(20);
      check("R10", "no flags", {28'd0, irq_o}, 0);
      check("R10", "still running", {31'd0, running_o}, 1);
      check("R10", "no zeroing", {31'd0, count_o > 10}, 1);

      idle(2);
      summary();
   end

endmodule